// File: doc/BRIEF.md
# Two-Line Static Bridge Emulator

This block sits between two logic nets and reproduces how a static short between them would corrupt their values. Each line's faulted value depends on a per-line behaviour function chosen from four: constant 0, constant 1, the other line, or the other line inverted. The chosen function only acts while the two lines disagree. When the lines carry equal values, both pass through unchanged, whatever the configuration.

A configuration write stores the two 2-bit selectors. One cycle later it also stores a canonical kind code from 0 to 9 and a swap bit. The sixteen selector pairs fall into ten kinds, because exchanging the roles of the two lines does not produce a new kind of bridge. The kind code names the unordered pair of selectors, and the swap bit records that the write put them in descending order. The line path is combinational: there is no handshake and no back-pressure. Each input pair produces a faulted pair and an error flag in the same cycle, using the configuration held in the register.

Top module: `bridge_emu`

## Requirements
- R1: In reset the held configuration is fault-free: both selectors 0, kind 0, swap 0, and the outputs equal the inputs.
- R2: When line_a equals line_b, out_a equals line_a and out_b equals line_b under every configuration.
- R3: The selector for line a is encoded as 0 = constant 0 (line keeps its value), 1 = constant 1 (line takes line_b), 2 = line_b (out_a = a OR b), 3 = inverted line_b (out_a = a AND b). These apply only when the lines differ.
- R4: The selector for line b uses the same encoding, with line_a as the other line.
- R5: A selector pair is captured on a clock edge where cfg_wr is high and governs the outputs from that edge on. While cfg_wr is low, the selector inputs have no effect.
- R6: err is high exactly when (out_a, out_b) differs from (line_a, line_b).
- R7: Let p be the smaller selector and q the larger. The kind code is then 4p - p(p-1)/2 + (q - p), which gives 0 fault-free, 1 a dominates b, 2 a OR-dominates b, 3 a AND-dominates b, 4 value swap, 7 wired-OR, 9 wired-AND. The kind code never exceeds 9.
- R8: swap is 1 exactly when the captured line-a selector is greater than the line-b selector. Two configurations that differ only by exchanging their selectors report the same kind.
- R9: kind and swap change only on the clock edge that captures a write, so they are visible one cycle after cfg_wr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Capture selector inputs on this edge |
| cfg_sel_a | input | 2 | Behaviour selector for line a |
| cfg_sel_b | input | 2 | Behaviour selector for line b |
| line_a | input | 1 | Fault-free value of line a |
| line_b | input | 1 | Fault-free value of line b |
| out_a | output | 1 | Faulted value of line a |
| out_b | output | 1 | Faulted value of line b |
| err | output | 1 | Bridge currently alters a line |
| kind | output | 4 | Canonical bridge kind code |
| swap | output | 1 | Written selectors were in role-swapped order |

## Verification
Some properties are checked on every cycle. Equal inputs always pass through, and an error can only occur while the lines disagree. The kind code stays within range, holds still between writes, and is always paired with the right swap bit. A fault-free kind never raises err. The exact function each selector produces, and the kind number for each of the sixteen pairs, are shown only by the bench's walk over the whole configuration and input space. The same is true of the one-cycle latency and of selector changes being ignored while no write is presented.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int SEL_W  = 2;
  localparam int KIND_W = 4;
  localparam int NSEL   = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_ZERO = 2'd0,
    SEL_ONE  = 2'd1,
    SEL_SAME = 2'd2,
    SEL_INV  = 2'd3
  } sel_e;

  // index of unordered pair (lo <= hi) among the triangular set of pairs
  function automatic logic [KIND_W-1:0] pair_code(input logic [SEL_W-1:0] lo,
                                                  input logic [SEL_W-1:0] hi);
    int p, q, r;
    p = int'(lo);
    q = int'(hi);
    r = p * NSEL - (p * (p - 1)) / 2 + (q - p);
    return KIND_W'(r);
  endfunction
endpackage

// File: rtl/bridge_line.sv
module bridge_line
  import bridge_pkg::*;
(
  input  logic             own,
  input  logic             other,
  input  logic [SEL_W-1:0] sel,
  output logic             faulted
);
  logic func;
  logic differ;

  always_comb begin
    unique case (sel_e'(sel))
      SEL_ZERO: func = 1'b0;
      SEL_ONE:  func = 1'b1;
      SEL_SAME: func = other;
      SEL_INV:  func = ~other;
      default:  func = 1'b0;
    endcase
  end

  assign differ  = own ^ other;
  assign faulted = own ^ (func & differ);
endmodule

// File: rtl/bridge_cfg.sv
module bridge_cfg
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel_a_in,
  input  logic [SEL_W-1:0]  sel_b_in,
  output logic [SEL_W-1:0]  sel_a_q,
  output logic [SEL_W-1:0]  sel_b_q,
  output logic [KIND_W-1:0] kind_q,
  output logic              swap_q
);
  logic              desc;
  logic [SEL_W-1:0]  lo, hi;
  logic [KIND_W-1:0] code;

  always_comb begin
    desc = sel_a_in > sel_b_in;
    lo   = desc ? sel_b_in : sel_a_in;
    hi   = desc ? sel_a_in : sel_b_in;
    code = pair_code(lo, hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_a_q <= '0;
      sel_b_q <= '0;
      kind_q  <= '0;
      swap_q  <= 1'b0;
    end else if (wr) begin
      sel_a_q <= sel_a_in;
      sel_b_q <= sel_b_in;
      kind_q  <= code;
      swap_q  <= desc;
    end
  end
endmodule

// File: rtl/bridge_emu.sv
module bridge_emu
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel_a,
  input  logic [SEL_W-1:0]  cfg_sel_b,
  input  logic              line_a,
  input  logic              line_b,
  output logic              out_a,
  output logic              out_b,
  output logic              err,
  output logic [KIND_W-1:0] kind,
  output logic              swap
);
  localparam int NLINE = 2;

  logic [NLINE-1:0][SEL_W-1:0] sel_q;
  logic [NLINE-1:0]            in_v;
  logic [NLINE-1:0]            out_v;

  bridge_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .sel_a_in (cfg_sel_a),
    .sel_b_in (cfg_sel_b),
    .sel_a_q  (sel_q[0]),
    .sel_b_q  (sel_q[1]),
    .kind_q   (kind),
    .swap_q   (swap)
  );

  assign in_v = {line_b, line_a};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    bridge_line u_line (
      .own     (in_v[g]),
      .other   (in_v[NLINE-1-g]),
      .sel     (sel_q[g]),
      .faulted (out_v[g])
    );
  end

  assign out_a = out_v[0];
  assign out_b = out_v[1];
  assign err   = |(out_v ^ in_v);
endmodule

// File: rtl/bridge_emu_chk.sv
module bridge_emu_chk
  import bridge_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [SEL_W-1:0]  cfg_sel_a,
  input logic [SEL_W-1:0]  cfg_sel_b,
  input logic              line_a,
  input logic              line_b,
  input logic              out_a,
  input logic              out_b,
  input logic              err,
  input logic [KIND_W-1:0] kind,
  input logic              swap
);
  // R2
  equal_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_a == line_b) |-> (out_a == line_a && out_b == line_b));

  // R6
  err_needs_differ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (line_a != line_b));

  // R7
  kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind <= KIND_W'(9));

  // R9
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(kind) && $stable(swap)));

  // R8
  swap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (swap == ($past(cfg_sel_a) > $past(cfg_sel_b))));

  // R1
  clean_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == '0) |-> !err);
endmodule

bind bridge_emu bridge_emu_chk u_chk (.*);

// File: tb/bridge_emu_test.sv
module bridge_emu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_sel_a = '0;
  logic [1:0] cfg_sel_b = '0;
  logic       line_a = 1'b0;
  logic       line_b = 1'b0;
  logic       out_a, out_b, err, swap;
  logic [3:0] kind;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bridge_emu uut (.*);

  // {swap, kind} for index sel_a*4 + sel_b
  localparam logic [4:0] KTAB [16] = '{
    5'h00, 5'h01, 5'h02, 5'h03,
    5'h11, 5'h04, 5'h05, 5'h06,
    5'h12, 5'h15, 5'h07, 5'h08,
    5'h13, 5'h16, 5'h18, 5'h09
  };

  function automatic logic exp_line(input logic own, input logic other, input logic [1:0] s);
    if (own == other) return own;
    case (s)
      2'd0: return own;
      2'd1: return other;
      2'd2: return own | other;
      default: return own & other;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [1:0] sa, input logic [1:0] sb);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel_a = sa; cfg_sel_b = sb;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic check_lines(input string req, input logic [1:0] sa, input logic [1:0] sb);
    for (int v = 0; v < 4; v++) begin
      logic ea, eb;
      line_a = v[0]; line_b = v[1];
      #1;
      ea = exp_line(v[0], v[1], sa);
      eb = exp_line(v[1], v[0], sb);
      check(req, {5'd0, out_a, out_b, err}, {5'd0, ea, eb, (ea != v[0]) || (eb != v[1])});
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 kind/swap", {3'd0, swap, kind}, 8'h00);
    check_lines("R1 pass", 2'd0, 2'd0);
    rst_n = 1'b1;

    // R3 R4 R6 R7 R8: full table walk
    for (int i = 0; i < 16; i++) begin
      logic [1:0] sa, sb;
      sa = 2'(i / 4); sb = 2'(i % 4);
      write_cfg(sa, sb);
      #1;
      check("R7 R8 kind", {3'd0, swap, kind}, {3'd0, KTAB[i]});
      check_lines("R3 R4 R6 lines", sa, sb);
    end

    // R9: one-cycle latency, kind old before the edge
    write_cfg(2'd3, 2'd3);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel_a = 2'd0; cfg_sel_b = 2'd1;
    #1 check("R9 before edge", {3'd0, swap, kind}, 8'h09);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1 check("R9 after edge", {3'd0, swap, kind}, 8'h01);

    // R5: selectors ignored without write
    cfg_sel_a = 2'd1; cfg_sel_b = 2'd1;
    repeat (2) @(negedge clk);
    #1 check("R5 held kind", {3'd0, swap, kind}, 8'h01);
    check_lines("R5 held lines", 2'd0, 2'd1);

    // R8: role-swapped pair same kind
    write_cfg(2'd3, 2'd0);
    #1 check("R8 swapped", {3'd0, swap, kind}, 8'h13);

    // R2: equal inputs under swap-values bridge
    write_cfg(2'd1, 2'd1);
    line_a = 1'b1; line_b = 1'b1;
    #1 check("R2 equal", {6'd0, out_a, out_b}, 8'h03);
    line_a = 1'b1; line_b = 1'b0;
    #1 check("R6 swap err", {5'd0, out_a, out_b, err}, 8'h03);

    // R1: reset returns to fault-free
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 re-reset", {3'd0, swap, kind}, 8'h00);
    check("R1 re-reset lines", {5'd0, out_a, out_b, err}, 8'h04);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule